// File: doc/BRIEF.md
# Read completion reorder buffer

This block collects read-completion data that a data mover pushes in bursts through a memory-mapped write slave. The completions may land in any order. The buffer holds four slots of 4 KB, one per outstanding read descriptor. Once a slot's descriptor is reported done, the block streams that slot's contents out in ascending line order. Each output word is 264 bits: a 256-bit line with an 8-bit dword-valid mask below it.

A descriptor controller announces each read descriptor on the issue port. Slots are handed out in ring order, so the n-th accepted descriptor owns slot n mod 4. The controller programs that descriptor's destination address so that it falls into the slot. Done status words come back on the status port. A slot drains only when its status has arrived and every older slot has already drained. While a write targets a slot that cannot take data, the slave holds off the master with waitrequest.

Top module: `rdcpl_reorder_buf`

## Requirements
- R1: After reset, desc_issue_ready is 1, so_valid is 0, and mm_waitreq is 0 while no write is requested.
- R2: Accepted descriptors take slots 0,1,2,3,0,... in issue order. desc_issue_ready is 0 exactly when all four slots are held, and an issue offered while it is 0 is not taken.
- R3: A write with mm_write and mm_chipsel both high raises mm_waitreq in the same cycle when its target slot is not allocated or has already received its done status. While mm_waitreq is high, the beat is not stored.
- R4: Address bits [13:12] pick the slot and bits [11:5] pick the 256-bit line. All other address bits are ignored. In a burst with mm_burstcnt greater than 1, the second and later beats go to the following lines of the same slot, and the address on those beats is ignored.
- R5: Dword-valid bit i of a line is set when byte enables 4i to 4i+3 are all high in one write. The bits are ORed over all writes to that line. Only enabled bytes update the data. so_payload[7:0] carries the mask and so_payload[263:8] carries the line data.
- R6: A status word is acted on only when bit 8 (done) is 1 and bits [7:0] equal the id of a slot that is still waiting for data. Any other status word changes nothing.
- R7: Slots drain strictly oldest first. A done slot behind an older slot that is not yet done produces no output until the older one has drained.
- R8: A draining slot emits lines 0 up to the highest line written, in ascending order. A line inside that range that was never written comes out with mask 0. After the last line, the slot becomes free and desc_issue_ready returns to 1.
- R9: The output has ready latency 0. A word is taken when so_valid and so_ready are both high. While so_valid is high and so_ready is low, so_valid and so_payload stay stable.
- R10: When a slot is reused, every line mask from its earlier descriptor reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_issue_valid | input | 1 | A read descriptor is being issued |
| desc_issue_id | input | 8 | Id of the issued descriptor |
| desc_issue_ready | output | 1 | A free slot is available |
| stat_valid | input | 1 | Status word present |
| stat_word | input | 32 | Status: [8] done, [7:0] descriptor id |
| mm_write | input | 1 | Write strobe of the slave |
| mm_chipsel | input | 1 | Chip select of the slave |
| mm_addr | input | 64 | Write address |
| mm_wdata | input | 256 | Write data |
| mm_byteen | input | 32 | Byte enables |
| mm_burstcnt | input | 5 | Beats in the burst |
| mm_waitreq | output | 1 | Write cannot be accepted this cycle |
| so_valid | output | 1 | Output word valid |
| so_ready | input | 1 | Downstream accepts the word |
| so_payload | output | 264 | [263:8] line data, [7:0] dword-valid mask |

## Verification
The bench feeds partial and overlapping byte-enable patterns into one line. A design with a wrong conversion or without the OR merge would report a wrong mask. It makes a younger slot go done before an older one; a design that ignored the ring order would stream the younger slot first. A burst carries junk addresses on its later beats, so a design that decoded every beat would scatter the data. It then reuses a drained slot, and a design that left old masks behind would mark stale dwords valid. It also sends status words with the done bit low or with an unknown id, and a design that accepted them would start draining too early.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int DATA_W        = 256;
  localparam int BE_W          = DATA_W / 8;
  localparam int DWORDS        = DATA_W / 32;
  localparam int ADDR_W        = 64;
  localparam int BURST_W       = 5;
  localparam int STAT_W        = 32;
  localparam int STAT_DONE_BIT = 8;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_FILL = 2'd1,
    SLOT_DONE = 2'd2
  } slot_state_e;

  // a dword counts as valid only when all four of its bytes are enabled
  function automatic logic [DWORDS-1:0] be_to_dwv(input logic [BE_W-1:0] be);
    logic [DWORDS-1:0] m;
    for (int i = 0; i < DWORDS; i++) m[i] = &be[4*i +: 4];
    return m;
  endfunction
endpackage

// File: rtl/rob_slot_ctrl.sv
module rob_slot_ctrl
  import rob_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LINES = 128,
  parameter int ID_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [ID_W-1:0]   issue_id,
  output logic              issue_ready,
  input  logic              stat_valid,
  input  logic [STAT_W-1:0] stat_word,
  input  logic              wr_beat,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              out_ready,
  output logic [SLOTS-1:0]  slot_fill,
  output logic [SLOT_W-1:0] head,
  output logic [LINE_W-1:0] rd_line,
  output logic              out_valid,
  output logic              drain_beat,
  output logic              alloc_fire,
  output logic              slot_freed
);
  slot_state_e       st   [SLOTS];
  logic [ID_W-1:0]   sid  [SLOTS];
  logic [LINE_W-1:0] smax [SLOTS];
  logic [SLOT_W-1:0] tail;
  logic [SLOTS-1:0]  stat_hit;
  logic              last_line;
  logic [STAT_W-1:STAT_DONE_BIT+1] unused_stat_bits;

  assign unused_stat_bits = stat_word[STAT_W-1:STAT_DONE_BIT+1];
  assign issue_ready = (st[tail] == SLOT_FREE);
  assign alloc_fire  = issue_valid && issue_ready;
  assign out_valid   = (st[head] == SLOT_DONE);
  assign drain_beat  = out_valid && out_ready;
  assign last_line   = (rd_line == smax[head]);
  assign slot_freed  = drain_beat && last_line;

  for (genvar s = 0; s < SLOTS; s++) begin : g_flags
    assign slot_fill[s] = (st[s] == SLOT_FILL);
    assign stat_hit[s]  = stat_valid && stat_word[STAT_DONE_BIT]
                          && (stat_word[ID_W-1:0] == sid[s])
                          && (st[s] == SLOT_FILL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        st[s]   <= SLOT_FREE;
        sid[s]  <= '0;
        smax[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (alloc_fire && tail == SLOT_W'(s)) begin
          st[s]   <= SLOT_FILL;
          sid[s]  <= issue_id;
          smax[s] <= '0;
        end else if (stat_hit[s]) begin
          st[s] <= SLOT_DONE;
        end else if (slot_freed && head == SLOT_W'(s)) begin
          st[s] <= SLOT_FREE;
        end
        if (wr_beat && wr_slot == SLOT_W'(s) && wr_line > smax[s])
          smax[s] <= wr_line;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail    <= '0;
      head    <= '0;
      rd_line <= '0;
    end else begin
      if (alloc_fire) tail <= tail + SLOT_W'(1);
      if (drain_beat) begin
        if (last_line) begin
          rd_line <= '0;
          head    <= head + SLOT_W'(1);
        end else begin
          rd_line <= rd_line + LINE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rob_wr_port.sv
module rob_wr_port
  import rob_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LINES = 128,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int LINE_W   = $clog2(LINES),
  localparam int LINE_LSB = $clog2(BE_W),
  localparam int SLOT_LSB = LINE_LSB + LINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mm_write,
  input  logic               mm_chipsel,
  input  logic [ADDR_W-1:0]  mm_addr,
  input  logic [BE_W-1:0]    mm_byteen,
  input  logic [BURST_W-1:0] mm_burstcnt,
  input  logic [SLOTS-1:0]   slot_fill,
  output logic               mm_waitreq,
  output logic               wr_beat,
  output logic [SLOT_W-1:0]  wr_slot,
  output logic [LINE_W-1:0]  wr_line,
  output logic [DWORDS-1:0]  wr_dwv,
  output logic               in_burst
);
  logic [SLOT_W-1:0]  a_slot, b_slot;
  logic [LINE_W-1:0]  a_line, b_line;
  logic [BURST_W-1:0] b_left;
  logic               req;
  logic               unused_addr_bits;

  assign unused_addr_bits = ^{mm_addr[ADDR_W-1:SLOT_LSB+SLOT_W], mm_addr[LINE_LSB-1:0]};
  assign a_slot     = mm_addr[SLOT_LSB +: SLOT_W];
  assign a_line     = mm_addr[LINE_LSB +: LINE_W];
  assign wr_slot    = in_burst ? b_slot : a_slot;
  assign wr_line    = in_burst ? b_line : a_line;
  assign req        = mm_write && mm_chipsel;
  assign mm_waitreq = req && !slot_fill[wr_slot];
  assign wr_beat    = req && slot_fill[wr_slot];
  assign wr_dwv     = be_to_dwv(mm_byteen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst <= 1'b0;
      b_slot   <= '0;
      b_line   <= '0;
      b_left   <= '0;
    end else if (wr_beat) begin
      if (!in_burst) begin
        if (mm_burstcnt > BURST_W'(1)) begin
          in_burst <= 1'b1;
          b_left   <= mm_burstcnt - BURST_W'(1);
          b_slot   <= a_slot;
          b_line   <= a_line + LINE_W'(1);
        end
      end else begin
        b_line <= b_line + LINE_W'(1);
        b_left <= b_left - BURST_W'(1);
        if (b_left == BURST_W'(1)) in_burst <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_line_store.sv
module rob_line_store
  import rob_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LINES = 128,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = $clog2(LINES),
  localparam int DEPTH  = SLOTS * LINES,
  localparam int IDX_W  = SLOT_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DWORDS-1:0] wr_dwv,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [LINE_W-1:0] rd_line,
  output logic [DATA_W-1:0] rd_data,
  output logic [DWORDS-1:0] rd_dwv
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DWORDS-1:0] dwv [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx  = {wr_slot, wr_line};
  assign rd_idx  = {rd_slot, rd_line};
  assign rd_data = mem[rd_idx];
  assign rd_dwv  = dwv[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < BE_W; b++)
        if (wr_be[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
  end

  // masks merge on write and clear as each line leaves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dwv[i] <= '0;
    end else begin
      if (wr_en)  dwv[wr_idx] <= dwv[wr_idx] | wr_dwv;
      if (clr_en) dwv[rd_idx] <= '0;
    end
  end
endmodule

// File: rtl/rdcpl_reorder_buf.sv
module rdcpl_reorder_buf
  import rob_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LINES = 128,
  parameter int ID_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = $clog2(LINES),
  localparam int OUT_W  = DATA_W + DWORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_issue_valid,
  input  logic [ID_W-1:0]    desc_issue_id,
  output logic               desc_issue_ready,
  input  logic               stat_valid,
  input  logic [STAT_W-1:0]  stat_word,
  input  logic               mm_write,
  input  logic               mm_chipsel,
  input  logic [ADDR_W-1:0]  mm_addr,
  input  logic [DATA_W-1:0]  mm_wdata,
  input  logic [BE_W-1:0]    mm_byteen,
  input  logic [BURST_W-1:0] mm_burstcnt,
  output logic               mm_waitreq,
  output logic               so_valid,
  input  logic               so_ready,
  output logic [OUT_W-1:0]   so_payload
);
  logic              wr_beat, in_burst;
  logic [SLOT_W-1:0] wr_slot, head;
  logic [LINE_W-1:0] wr_line, rd_line;
  logic [DWORDS-1:0] wr_dwv, rd_dwv;
  logic [SLOTS-1:0]  slot_fill;
  logic              drain_beat, alloc_fire, slot_freed;
  logic [DATA_W-1:0] rd_data;

  rob_wr_port #(.SLOTS(SLOTS), .LINES(LINES)) u_wr (
    .clk, .rst_n, .mm_write, .mm_chipsel, .mm_addr, .mm_byteen, .mm_burstcnt,
    .slot_fill, .mm_waitreq, .wr_beat, .wr_slot, .wr_line, .wr_dwv, .in_burst
  );

  rob_slot_ctrl #(.SLOTS(SLOTS), .LINES(LINES), .ID_W(ID_W)) u_ctrl (
    .clk, .rst_n,
    .issue_valid(desc_issue_valid), .issue_id(desc_issue_id), .issue_ready(desc_issue_ready),
    .stat_valid, .stat_word, .wr_beat, .wr_slot, .wr_line,
    .out_ready(so_ready), .slot_fill, .head, .rd_line,
    .out_valid(so_valid), .drain_beat, .alloc_fire, .slot_freed
  );

  rob_line_store #(.SLOTS(SLOTS), .LINES(LINES)) u_store (
    .clk, .rst_n, .wr_en(wr_beat), .wr_slot, .wr_line, .wr_data(mm_wdata),
    .wr_be(mm_byteen), .wr_dwv, .clr_en(drain_beat), .rd_slot(head), .rd_line,
    .rd_data, .rd_dwv
  );

  assign so_payload = {rd_data, rd_dwv};
endmodule

// File: rtl/rdcpl_reorder_chk.sv
module rdcpl_reorder_chk #(
  parameter int SLOTS = 4,
  parameter int LINES = 128,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = $clog2(LINES),
  localparam int OCC_W  = SLOT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_issue_ready,
  input logic              so_valid,
  input logic              so_ready,
  input logic [263:0]      so_payload,
  input logic              wr_beat,
  input logic [LINE_W-1:0] wr_line,
  input logic              in_burst,
  input logic              drain_beat,
  input logic              slot_freed,
  input logic              alloc_fire,
  input logic [LINE_W-1:0] rd_line
);
  logic [OCC_W-1:0]  occ;
  logic [LINE_W-1:0] prev_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ       <= '0;
      prev_line <= '0;
    end else begin
      occ <= occ + OCC_W'(alloc_fire) - OCC_W'(slot_freed);
      if (wr_beat) prev_line <= wr_line;
    end
  end

  // R9
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid && !so_ready |=> so_valid && $stable(so_payload));

  // R2
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_issue_ready == (occ != OCC_W'(SLOTS)));

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat && in_burst |-> wr_line == LINE_W'(prev_line + LINE_W'(1)));

  // R8
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_beat && !slot_freed |=> rd_line == LINE_W'($past(rd_line) + LINE_W'(1)));

  // R8
  drain_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_freed |=> rd_line == '0);

  // R7
  valid_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid |-> occ != '0);
endmodule

bind rdcpl_reorder_buf rdcpl_reorder_chk #(.SLOTS(SLOTS), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_issue_ready(desc_issue_ready),
  .so_valid(so_valid), .so_ready(so_ready), .so_payload(so_payload),
  .wr_beat(wr_beat), .wr_line(wr_line), .in_burst(in_burst),
  .drain_beat(drain_beat), .slot_freed(slot_freed), .alloc_fire(alloc_fire),
  .rd_line(rd_line)
);

// File: tb/rdcpl_reorder_buf_test.sv
module rdcpl_reorder_buf_test;
  localparam int SLOTS = 4;
  localparam int LINES = 128;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         desc_issue_valid;
  logic [7:0]   desc_issue_id;
  logic         desc_issue_ready;
  logic         stat_valid;
  logic [31:0]  stat_word;
  logic         mm_write, mm_chipsel;
  logic [63:0]  mm_addr;
  logic [255:0] mm_wdata;
  logic [31:0]  mm_byteen;
  logic [4:0]   mm_burstcnt;
  logic         mm_waitreq;
  logic         so_valid, so_ready;
  logic [263:0] so_payload;

  always #2 clk = ~clk;

  rdcpl_reorder_buf uut (
    .clk, .rst_n, .desc_issue_valid, .desc_issue_id, .desc_issue_ready,
    .stat_valid, .stat_word, .mm_write, .mm_chipsel, .mm_addr, .mm_wdata,
    .mm_byteen, .mm_burstcnt, .mm_waitreq, .so_valid, .so_ready, .so_payload
  );

  int checks = 0;
  int errors = 0;

  logic [255:0] mdl_data [SLOTS][LINES];
  logic [7:0]   mdl_dwv  [SLOTS][LINES];
  int           mdl_max  [SLOTS];

  // {line[7], byte enables[32], expected mask[8], data seed[8]} all into slot 0
  localparam logic [54:0] TAB [6] = '{
    {7'd0, 32'hFFFF_FFFF, 8'hFF, 8'h10},
    {7'd2, 32'h0000_000F, 8'h01, 8'h20},
    {7'd2, 32'hF000_0000, 8'h80, 8'h30},
    {7'd3, 32'h00FF_0F00, 8'h34, 8'h40},
    {7'd3, 32'h0000_0077, 8'h00, 8'h50},
    {7'd5, 32'h0F0F_0F0F, 8'h55, 8'h60}
  };

  task automatic chk(input bit ok, input string what, input logic [263:0] act, input logic [263:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [255:0] mkdata(input logic [7:0] seed);
    logic [255:0] d;
    for (int k = 0; k < 32; k++) d[8*k +: 8] = seed + 8'(k);
    return d;
  endfunction

  task automatic mm_put(input int slot, input int line, input int nbeats,
                        input logic [31:0] be, input logic [7:0] exp_dwv, input logic [7:0] seed);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      mm_write    = 1'b1;
      mm_chipsel  = 1'b1;
      mm_burstcnt = 5'(nbeats);
      mm_addr     = (b == 0) ? (64'hA5A5_0000_0000_0000 | (64'(slot) << 12) | (64'(line) << 5))
                             : 64'hFFFF_FFFF_FFFF_FFE0;
      mm_byteen   = be;
      mm_wdata    = mkdata(seed + 8'(b));
      #1 chk(mm_waitreq == 1'b0, "R3 write to waiting slot accepted", 264'(mm_waitreq), 264'(0));
      for (int k = 0; k < 32; k++)
        if (be[k]) mdl_data[slot][line+b][8*k +: 8] = mm_wdata[8*k +: 8];
      mdl_dwv[slot][line+b] = mdl_dwv[slot][line+b] | exp_dwv;
      if (line + b > mdl_max[slot]) mdl_max[slot] = line + b;
    end
    @(negedge clk);
    mm_write   = 1'b0;
    mm_chipsel = 1'b0;
  endtask

  task automatic mm_probe(input int slot, input string what);
    @(negedge clk);
    mm_write   = 1'b1;
    mm_chipsel = 1'b1;
    mm_addr    = 64'(slot) << 12;
    mm_burstcnt = 5'd1;
    #1 chk(mm_waitreq == 1'b1, what, 264'(mm_waitreq), 264'(1));
    mm_write   = 1'b0;
    mm_chipsel = 1'b0;
  endtask

  task automatic issue(input logic [7:0] id, input logic exp_ready, input string what);
    @(negedge clk);
    desc_issue_valid = 1'b1;
    desc_issue_id    = id;
    #1 chk(desc_issue_ready == exp_ready, what, 264'(desc_issue_ready), 264'(exp_ready));
    @(negedge clk);
    desc_issue_valid = 1'b0;
  endtask

  task automatic status(input logic [31:0] w);
    @(negedge clk);
    stat_valid = 1'b1;
    stat_word  = w;
    @(negedge clk);
    stat_valid = 1'b0;
  endtask

  task automatic expect_idle(input string what);
    @(negedge clk);
    #1 chk(so_valid == 1'b0, what, 264'(so_valid), 264'(0));
  endtask

  task automatic drain_slot(input int slot, input bit hold, input string what);
    logic [263:0] p0;
    logic [255:0] dm;
    for (int l = 0; l <= mdl_max[slot]; l++) begin
      @(negedge clk);
      if (hold && l == 0) begin
        so_ready = 1'b0;
        #1 p0 = so_payload;
        @(negedge clk);
        #1 chk(so_valid && so_payload == p0, "R9 word held while not ready", so_payload, p0);
      end
      so_ready = 1'b1;
      #1;
      dm = '0;
      for (int i = 0; i < 8; i++) if (mdl_dwv[slot][l][i]) dm[32*i +: 32] = '1;
      chk(so_valid == 1'b1, {what, " valid"}, 264'(so_valid), 264'(1));
      chk(so_payload[7:0] == mdl_dwv[slot][l], {what, " R5 mask"},
          264'(so_payload[7:0]), 264'(mdl_dwv[slot][l]));
      chk((so_payload[263:8] & dm) == (mdl_data[slot][l] & dm), {what, " R5 data"},
          264'(so_payload[263:8] & dm), 264'(mdl_data[slot][l] & dm));
    end
    @(negedge clk);
    so_ready = 1'b0;
    for (int l = 0; l <= mdl_max[slot]; l++) mdl_dwv[slot][l] = '0;
    mdl_max[slot] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      mdl_max[s] = 0;
      for (int l = 0; l < LINES; l++) begin
        mdl_data[s][l] = '0;
        mdl_dwv[s][l]  = '0;
      end
    end
    rst_n = 1'b0;
    desc_issue_valid = 1'b0; desc_issue_id = '0;
    stat_valid = 1'b0; stat_word = '0;
    mm_write = 1'b0; mm_chipsel = 1'b0; mm_addr = '0; mm_wdata = '0;
    mm_byteen = '0; mm_burstcnt = 5'd1; so_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    #1;
    chk(desc_issue_ready == 1'b1, "R1 issue ready after reset", 264'(desc_issue_ready), 264'(1));
    chk(so_valid == 1'b0, "R1 no output after reset", 264'(so_valid), 264'(0));
    chk(mm_waitreq == 1'b0, "R1 waitreq idle", 264'(mm_waitreq), 264'(0));

    mm_probe(0, "R3 unallocated slot stalls");
    issue(8'h11, 1'b1, "R2 first issue taken");
    mm_probe(1, "R2 first descriptor owns slot 0 not 1");

    // table of byte-enable patterns into slot 0
    for (int i = 0; i < 6; i++)
      mm_put(0, int'(TAB[i][54:48]), 1, TAB[i][47:16], TAB[i][15:8], TAB[i][7:0]);

    status(32'h0000_0011);
    expect_idle("R6 status without done bit ignored");
    status(32'h0000_0155);
    expect_idle("R6 status for unknown id ignored");
    status(32'h0000_0111);
    mm_probe(0, "R3 done slot stalls writes");
    drain_slot(0, 1'b1, "R8 slot0 table drain");
    #1;
    chk(so_valid == 1'b0, "R8 output ends after last line", 264'(so_valid), 264'(0));
    chk(desc_issue_ready == 1'b1, "R8 slot freed", 264'(desc_issue_ready), 264'(1));

    // ring order and out-of-order completion
    issue(8'h21, 1'b1, "R2 issue 0x21");
    mm_probe(2, "R2 slot 2 not yet allocated");
    issue(8'h22, 1'b1, "R2 issue 0x22");
    issue(8'h23, 1'b1, "R2 issue 0x23");
    issue(8'h24, 1'b1, "R2 issue 0x24");
    issue(8'h99, 1'b0, "R2 full buffer refuses issue");
    mm_put(2, 1, 3, 32'hFFFF_FFFF, 8'hFF, 8'hA0);   // R4 burst over lines 1..3
    mm_put(1, 0, 1, 32'hFFFF_FFFF, 8'hFF, 8'hB0);
    mm_put(3, 2, 1, 32'hFFFF_FFFF, 8'hFF, 8'hC0);
    mm_put(0, 0, 1, 32'hFFFF_FFFF, 8'hFF, 8'hD0);

    status(32'h0000_0122);
    expect_idle("R7 younger done slot waits for older");
    status(32'h0000_0121);
    drain_slot(1, 1'b0, "R7 slot1 drains first");
    drain_slot(2, 1'b0, "R4 R8 slot2 burst lines with empty line 0");
    #1 chk(so_valid == 1'b0, "R7 slot3 not done yet", 264'(so_valid), 264'(0));
    status(32'h0000_0124);
    expect_idle("R7 slot0 waits behind slot3");
    status(32'h0000_0123);
    drain_slot(3, 1'b0, "R7 slot3");
    drain_slot(0, 1'b0, "R7 slot0 after slot3");

    // R10 slot 1 reused: its old line 0 must read as empty
    issue(8'h25, 1'b1, "R2 issue 0x25 reuses slot 1");
    mm_put(1, 1, 1, 32'hFFFF_FFFF, 8'hFF, 8'hE0);
    status(32'h0000_0125);
    drain_slot(1, 1'b0, "R10 reused slot old mask cleared");
    #1 chk(so_valid == 1'b0, "R8 all slots drained", 264'(so_valid), 264'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule